// File: doc/BRIEF.md
# Supervisor-Domain Protection Root Register

This block is a machine-level control register that configures physical memory protection across supervisor domains. It holds three fields: a protection mode, a supervisor domain identifier (SDID), and the page number of the root protection table. Requests arrive tagged with the privilege level of the requester. Only machine mode may touch the register, and every accepted write passes through a legalization step, so that the stored value is always one that the downstream table walker can use.

Writes are never dropped because a field is out of range. Each field is legalized on its own. A reserved mode value keeps the previous mode. Bare mode clears the identifier and the root page number. The table modes clear the two low bits of the root page number. Only the implemented identifier bits are kept, so software can find the identifier width by writing all ones and reading the value back. A Bare write that carries nonzero fields still completes in its legal form, but a fault is flagged. The legalized fields are held in flops and driven to the walker, together with a one-cycle change strobe that the walker uses to flush its state.

Top module: `prot_root_csr`

## Requirements
- R1: After reset the register reads as mode Bare with SDID and root page number zero, and the change strobe is low.
- R2: A request with `req_priv` other than 2'b11 (machine) raises `illegal_insn` in the same cycle, returns zero on `rd_data`, and leaves the register and the strobe unchanged.
- R3: The word layout is mode in bits [31:30], SDID in bits [29:22] and root page number in bits [21:0]. An accepted write is visible on the next clock edge, and a machine read returns the current legalized value in the same cycle.
- R4: Mode codes are 2'b00 Bare, 2'b01 34-bit allow/deny and 2'b10 34-bit read/write. A write of the reserved code 2'b11 keeps the previous mode and legalizes the other fields against it.
- R5: When the resulting mode is Bare, the stored SDID and root page number are zero whatever was written.
- R6: A machine write with mode code 2'b00 and a nonzero SDID field or root page number field raises `bare_fault` in the request cycle. No other request raises it.
- R7: In the allow/deny and read/write modes, bits [1:0] of the stored root page number are always zero, and the remaining bits keep the written value.
- R8: Only the low `SDID_BITS` bits of the SDID field are stored (0 to 8). The others read as zero, so writing all ones returns ones exactly at the implemented positions.
- R9: `chg_strobe` is high for exactly the cycle after a write edge that changed the stored value. It stays low after a write that leaves the value the same.
- R10: A machine read (`req_write` low) does not change the register and does not pulse the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 2 | Effective privilege of the requester, 2'b11 = machine |
| req_wdata | input | 32 | Write data word |
| rd_data | output | 32 | Read data, valid in the request cycle |
| illegal_insn | output | 1 | Access attempted below machine privilege |
| bare_fault | output | 1 | Bare-mode write carried nonzero fields |
| mode_o | output | 2 | Stored protection mode |
| sdid_o | output | 8 | Stored SDID, unimplemented bits zero |
| ppn_o | output | 22 | Stored root table page number |
| chg_strobe | output | 1 | One-cycle pulse after the stored value changed |

## Verification
The hardest case to reach is a reserved-code write, because its result depends on the mode left by the write before it. The bench therefore preloads every legal mode with all-ones fields before each test write, and then sweeps all four codes against several identifier and page patterns. Doing the same write twice in a row and then reading exposes any strobe that fires on a no-change write.

// File: rtl/prot_root_pkg.sv
// Shared layout, mode codes and privilege code for the protection root register.
// Assumes a 32-bit register word whose fields fill it exactly.
package prot_root_pkg;
    localparam int XLEN     = 32;
    localparam int MODE_W   = 2;
    localparam int SDID_FW  = 8;
    localparam int PPN_W    = XLEN - MODE_W - SDID_FW;
    localparam int MODE_LSB = XLEN - MODE_W;
    localparam int SDID_LSB = PPN_W;

    typedef enum logic [MODE_W-1:0] {
        PM_BARE    = 2'b00,
        PM_ALLOW34 = 2'b01,
        PM_RW34    = 2'b10,
        PM_RSVD    = 2'b11
    } pmode_e;

    // The packed order matches the word layout, high bits first.
    typedef struct packed {
        pmode_e               mode;
        logic [SDID_FW-1:0]   sdid;
        logic [PPN_W-1:0]     ppn;
    } root_s;

    localparam logic [1:0] PRIV_M = 2'b11;
endpackage

// File: rtl/prot_priv_gate.sv
// Privilege gate: sorts an access request into accepted read, accepted write,
// or illegal access. Assumes the privilege code 2'b11 means machine mode.
module prot_priv_gate
    import prot_root_pkg::*;
(
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [1:0] req_priv,
    output logic       rd_ok,
    output logic       wr_ok,
    output logic       illegal
);
    logic is_m;

    // Classify the request by privilege and direction.
    always_comb begin
        is_m    = (req_priv == PRIV_M);
        rd_ok   = req_valid && is_m && !req_write;
        wr_ok   = req_valid && is_m && req_write;
        illegal = req_valid && !is_m;
    end
endmodule

// File: rtl/prot_field_legalizer.sv
// Write legalizer: works out the legal next register value from a raw write
// word and the current value, and flags a Bare write that has nonzero fields.
// Assumes 0 <= SDID_BITS <= 8.
module prot_field_legalizer
    import prot_root_pkg::*;
#(
    parameter int SDID_BITS = 4
) (
    input  root_s        cur,
    input  logic [31:0]  wdata,
    output root_s        nxt,
    output logic         bare_viol
);
    localparam logic [SDID_FW:0]   SDID_ONES = (SDID_FW+1)'((1 << SDID_BITS) - 1);
    localparam logic [SDID_FW-1:0] SDID_MASK = SDID_ONES[SDID_FW-1:0];

    logic [MODE_W-1:0]  raw_mode;
    logic [SDID_FW-1:0] raw_sdid;
    logic [PPN_W-1:0]   raw_ppn;
    logic [SDID_FW-1:0] kept_sdid;
    pmode_e             eff_mode;

    // Split the raw word along the register layout.
    always_comb begin
        raw_mode = wdata[MODE_LSB +: MODE_W];
        raw_sdid = wdata[SDID_LSB +: SDID_FW];
        raw_ppn  = wdata[0 +: PPN_W];
    end

    // Keep only the implemented SDID bits; full width passes straight through.
    generate
        if (SDID_BITS >= SDID_FW) begin : g_sdid_full
            assign kept_sdid = raw_sdid;
        end else begin : g_sdid_part
            assign kept_sdid = raw_sdid & SDID_MASK;
        end
    endgenerate

    // Pick the mode (the reserved code keeps the old one), then legalize the rest.
    always_comb begin
        eff_mode = (raw_mode == PM_RSVD) ? cur.mode : pmode_e'(raw_mode);
        nxt.mode = eff_mode;
        if (eff_mode == PM_BARE) begin
            nxt.sdid = '0;
            nxt.ppn  = '0;
        end else begin
            nxt.sdid = kept_sdid;
            nxt.ppn  = {raw_ppn[PPN_W-1:2], 2'b00};
        end
        bare_viol = (raw_mode == PM_BARE) && ((raw_sdid != '0) || (raw_ppn != '0));
    end
endmodule

// File: rtl/prot_root_reg.sv
// Storage for the legalized root value plus the change strobe.
// Assumes nxt is already legal; the strobe marks the cycle after a value change.
module prot_root_reg
    import prot_root_pkg::*;
#(
    parameter int SDID_BITS = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  root_s nxt,
    output root_s cur,
    output logic  strobe
);
    localparam logic [SDID_FW:0]   SDID_ONES = (SDID_FW+1)'((1 << SDID_BITS) - 1);
    localparam logic [SDID_FW-1:0] SDID_MASK = SDID_ONES[SDID_FW-1:0];

    // Hold the register; reset to Bare with zero fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '{mode: PM_BARE, sdid: '0, ppn: '0};
        end else if (wr_en) begin
            cur <= nxt;
        end
    end

    // Pulse the strobe when an accepted write alters the value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe <= 1'b0;
        end else begin
            strobe <= wr_en && (nxt != cur);
        end
    end

    // R4: the stored mode never holds the reserved code.
    a_r4_no_rsvd_mode: assert property (@(posedge clk) disable iff (!rst_n)
        cur.mode != PM_RSVD);
    // R5: Bare mode carries zero fields.
    a_r5_bare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.mode == PM_BARE) |-> (cur.sdid == '0 && cur.ppn == '0));
    // R7: the table modes keep the low page bits clear.
    a_r7_ppn_align: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.mode != PM_BARE) |-> (cur.ppn[1:0] == 2'b00));
    // R8: unimplemented SDID bits stay zero.
    a_r8_sdid_width: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.sdid & ~SDID_MASK) == '0);
    // R9: a strobe follows only a real change.
    a_r9_strobe_change: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (cur != $past(cur)));
    // R9: the register never changes without a strobe.
    a_r9_change_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (cur != $past(cur)) |-> strobe);
endmodule

// File: rtl/prot_root_csr.sv
// Top of the protection root register: gates access by privilege, legalizes
// writes field by field and drives the stored fields to a table walker.
// Assumes one request per cycle; reads see the value from before any write.
module prot_root_csr
    import prot_root_pkg::*;
#(
    parameter int SDID_BITS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_priv,
    input  logic [31:0] req_wdata,
    output logic [31:0] rd_data,
    output logic        illegal_insn,
    output logic        bare_fault,
    output logic [1:0]  mode_o,
    output logic [7:0]  sdid_o,
    output logic [21:0] ppn_o,
    output logic        chg_strobe
);
    logic  rd_ok;
    logic  wr_ok;
    logic  bare_viol;
    root_s cur;
    root_s nxt;

    prot_priv_gate u_gate (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_priv  (req_priv),
        .rd_ok     (rd_ok),
        .wr_ok     (wr_ok),
        .illegal   (illegal_insn)
    );

    prot_field_legalizer #(.SDID_BITS(SDID_BITS)) u_legal (
        .cur       (cur),
        .wdata     (req_wdata),
        .nxt       (nxt),
        .bare_viol (bare_viol)
    );

    prot_root_reg #(.SDID_BITS(SDID_BITS)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ok),
        .nxt    (nxt),
        .cur    (cur),
        .strobe (chg_strobe)
    );

    // Drive the read word, the fault flag and the fields for the walker.
    always_comb begin
        rd_data    = (rd_ok || wr_ok) ? cur : '0;
        bare_fault = wr_ok && bare_viol;
        mode_o     = cur.mode;
        sdid_o     = cur.sdid;
        ppn_o      = cur.ppn;
    end

    // R2: an access below machine mode leaves the register untouched.
    a_r2_unpriv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv != PRIV_M) |=> (cur == $past(cur)));
    // R10: a read leaves the register untouched.
    a_r10_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> (cur == $past(cur)));
    // R6: a fault never comes with an illegal access.
    a_r6_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bare_fault && illegal_insn));
endmodule

// File: tb/sim_prot_root_csr.sv
`timescale 1ns/1ps
module sim_prot_root_csr;
    localparam int SB = 5;
    localparam logic [7:0] SMASK = 8'((1 << SB) - 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_priv = 2'b11;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        illegal_insn, bare_fault, chg_strobe;
    logic [1:0]  mode_o;
    logic [7:0]  sdid_o;
    logic [21:0] ppn_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model state.
    logic [1:0]  em = 2'b00;
    logic [7:0]  es = '0;
    logic [21:0] ep = '0;

    always #4 clk = ~clk;

    prot_root_csr #(.SDID_BITS(SB)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_priv(req_priv), .req_wdata(req_wdata), .rd_data(rd_data),
        .illegal_insn(illegal_insn), .bare_fault(bare_fault), .mode_o(mode_o),
        .sdid_o(sdid_o), .ppn_o(ppn_o), .chg_strobe(chg_strobe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input logic exp_strobe);
        chk({mode_o, sdid_o, ppn_o} == {em, es, ep}, req, "stored fields",
            {mode_o, sdid_o, ppn_o}, {em, es, ep});
        chk(chg_strobe == exp_strobe, req, "strobe", 32'(chg_strobe), 32'(exp_strobe));
    endtask

    // One access; checks the same-cycle responses and the state after the edge.
    task automatic access(input logic [1:0] priv, input logic wr,
                          input logic [31:0] d, input string req);
        logic [1:0]  wm, nm;
        logic [7:0]  ws, ns;
        logic [21:0] wp, np;
        logic        efault, chg;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_priv = priv; req_wdata = d;
        #1;
        wm = d[31:30]; ws = d[29:22]; wp = d[21:0];
        efault = (priv == 2'b11) && wr && (wm == 2'b00) && (ws != 0 || wp != 0);
        chk(illegal_insn == (priv != 2'b11), req, "illegal_insn", 32'(illegal_insn), 32'(priv != 2'b11));
        chk(bare_fault == efault, req, "bare_fault", 32'(bare_fault), 32'(efault));
        chk(rd_data == ((priv == 2'b11) ? {em, es, ep} : 32'h0), req, "rd_data",
            rd_data, (priv == 2'b11) ? {em, es, ep} : 32'h0);
        nm = em; ns = es; np = ep;
        if (priv == 2'b11 && wr) begin
            nm = (wm == 2'b11) ? em : wm;
            ns = (nm == 2'b00) ? 8'h0 : (ws & SMASK);
            np = (nm == 2'b00) ? 22'h0 : {wp[21:2], 2'b00};
        end
        chg = {nm, ns, np} != {em, es, ep};
        em = nm; es = ns; ep = np;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        #1;
        chk_state(req, chg);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  sp [4];
        logic [21:0] pp [4];
        sp[0] = 8'h00; sp[1] = 8'hFF; sp[2] = 8'hA5; sp[3] = 8'h01;
        pp[0] = 22'h0; pp[1] = 22'h3FFFFF; pp[2] = 22'h2AAAAA; pp[3] = 22'h000003;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk_state("R1", 1'b0);
        access(2'b11, 1'b0, 32'h0, "R1");

        // R2: every non-machine level, read and write.
        access(2'b11, 1'b1, {2'b01, 8'h0A, 22'h12344}, "R3");
        for (int p = 0; p < 3; p++) begin
            access(2'(p), 1'b1, {2'b10, 8'h1F, 22'h3FFFF0}, "R2");
            access(2'(p), 1'b0, 32'h0, "R2");
        end

        // R3..R8: preload each legal mode, then every code against each pattern.
        for (int pm = 0; pm < 3; pm++)
            for (int wm = 0; wm < 4; wm++)
                for (int k = 0; k < 4; k++) begin
                    access(2'b11, 1'b1, {2'(pm), 8'hFF, 22'h3FFFFF}, "R3");
                    access(2'b11, 1'b1, {2'(wm), sp[k], pp[k]},
                           (wm == 3) ? "R4" : (wm == 0) ? "R6" : "R7");
                    access(2'b11, 1'b0, 32'h0, "R10");
                end

        // R8: width discovery by all ones.
        access(2'b11, 1'b1, {2'b01, 8'hFF, 22'h0}, "R8");
        chk(sdid_o == SMASK, "R8", "sdid width", 32'(sdid_o), 32'(SMASK));

        // R9: the same write twice; the second must not strobe.
        access(2'b11, 1'b1, {2'b10, 8'h03, 22'h00FF0}, "R9");
        access(2'b11, 1'b1, {2'b10, 8'h03, 22'h00FF1}, "R9");
        access(2'b11, 1'b0, 32'h0, "R10");

        // R5: a Bare write with zero fields clears everything without a fault.
        access(2'b11, 1'b1, 32'h0, "R5");
        chk(ppn_o == 0 && sdid_o == 0, "R5", "bare fields", {sdid_o, ppn_o}, 32'h0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule